// File: doc/BRIEF.md
# RTC Hibernation Wake Controller

This block is a memory-mapped real-time clock with a hibernation sequencer, reached over a plain 32-bit register bus with a one-cycle write and a combinational read. A seconds counter advances on a one-second tick from a prescaler. The counter can be preloaded and is compared against two match registers. Each match latches a raw status bit, and each status bit has its own mask bit feeding a single interrupt line.

A single write to the control register picks the wake sources and starts hibernation in the same access. While hibernating, the block holds a power-cut request output high. The request ends when an enabled wake source fires: a counter match, a low level on the external wake pin, or whichever comes first when both are enabled. Sixty-four retention words share the register map and keep their contents across the whole sequence.

The prescaler period is a parameter, so a bench can shorten the second to a few clocks.

Top module: `rtc_hib_ctrl`

## Requirements
- R1: After reset, the control, mask, match, load, counter, status and retention words all read 0, and both `hib_req_o` and `irq_o` are low.
- R2: The control word at offset 0x010 uses these bits: bit 0 counter run, bit 1 hibernate request, bit 2 clock mode, bit 3 match wake enable, bit 4 pin wake enable, bit 6 clock enable. Those bits read back as written. Bit 5 and bits 31:7 read 0.
- R3: A write to the load register (0x00C) is copied into the counter (read at 0x000) on the next tick, whether or not the counter is running. The prescaler runs only while bit 6 is set.
- R4: While bit 0 is set, the counter increments by exactly one per tick, and a tick comes every TICK_DIV clocks. While bit 0 is clear, the counter holds its value.
- R5: When the counter steps onto the value of match 0 (0x004) or match 1 (0x008) while running, raw status bit 0 or bit 1 at 0x018 sets. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R6: `irq_o` is high exactly when some raw status bit is set and its enable bit in the mask register (0x014, bit 0 for match 0, bit 1 for match 1) is also set.
- R7: Control word 0x41 starts counting without hibernating: `hib_req_o` stays low.
- R8: A control write with bit 1 set raises `hib_req_o` after that write's clock edge. The output stays high until an enabled wake source fires.
- R9: With bit 3 set, a counter match during hibernation drops `hib_req_o` and clears control bit 1. This applies to control words 0x4F and 0x5F.
- R10: With bit 4 set (0x56), a low level on `wake_pin_n`, passed through a two-stage synchronizer, ends hibernation within 3 clocks. With bit 4 clear, the pin has no effect.
- R11: With bit 3 clear (for example 0x57), a counter match still sets its status bit but does not end hibernation.
- R12: The retention words at 0x030 + 4*i (i = 0..63) read back what was written, and hibernation entry and wake leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| wake_pin_n | input | 1 | External wake pin, active low, asynchronous |
| hib_req_o | output | 1 | Power-cut request, high while hibernating |
| irq_o | output | 1 | Masked match interrupt |

## Verification
A wrong counter or pending-load state shows up on the next tick: the counter read at 0x000 returns a value off by at least one, so a count taken over a fixed number of prescaler periods detects it within TICK_DIV clocks. A stuck or missing raw status bit shows on `irq_o` and at 0x018 one clock after the match tick. A wrong wake decision shows on `hib_req_o` within one tick for match wake, or within three clocks of the pin falling for pin wake. Corrupted retention storage shows only when the word is read back, so every word is read after each wake.

// File: rtl/rtc_hib_pkg.sv
package rtc_hib_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_COUNT  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_MATCH0 = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_MATCH1 = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_LOAD   = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_MSTAT  = 12'h01C;
  localparam logic [ADDR_W-1:0] OFS_RET    = 12'h030;

  localparam int CB_RUN    = 0;
  localparam int CB_HIB    = 1;
  localparam int CB_CMODE  = 2;
  localparam int CB_MWAKE  = 3;
  localparam int CB_PWAKE  = 4;
  localparam int CB_CLKEN  = 6;
  localparam logic [31:0] CTRL_WMASK = 32'h0000_005F;

  // Value the counter takes at a tick.
  function automatic logic [31:0] next_count(input logic [31:0] cur,
                                             input logic        ld_pend,
                                             input logic [31:0] ld_val,
                                             input logic        run);
    if (ld_pend)  return ld_val;
    else if (run) return cur + 32'd1;
    else          return cur;
  endfunction

  // True when the address falls on a retention word.
  function automatic logic ret_hit(input logic [ADDR_W-1:0] a, input int words);
    return (a >= OFS_RET) && ({20'd0, a} < ({20'd0, OFS_RET} + 32'(4 * words)))
           && (a[1:0] == 2'b00);
  endfunction

  // Word index of a retention address.
  function automatic logic [ADDR_W-1:0] ret_index(input logic [ADDR_W-1:0] a);
    return (a - OFS_RET) >> 2;
  endfunction
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int TICK_DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick_o = run && (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (!run)   pre_q <= '0;
    else if (tick_o) pre_q <= '0;
    else             pre_q <= pre_q + PW'(1);
  end

  generate
    if (TICK_DIV > 1) begin : g_spacing
      a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        run,
  input  logic        ld_wr,
  input  logic [31:0] ld_val,
  input  logic [31:0] match0,
  input  logic [31:0] match1,
  output logic [31:0] cnt_o,
  output logic [1:0]  hit_o
);
  import rtc_hib_pkg::*;

  logic        ld_pend_q;
  logic [31:0] cnt_nxt;

  assign cnt_nxt  = next_count(cnt_o, ld_pend_q, ld_val, run);
  assign hit_o[0] = tick && run && (cnt_nxt == match0);
  assign hit_o[1] = tick && run && (cnt_nxt == match1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o     <= '0;
      ld_pend_q <= 1'b0;
    end else begin
      if (tick) cnt_o <= cnt_nxt;
      ld_pend_q <= ld_wr || (ld_pend_q && !tick);
    end
  end

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick && run && !ld_pend_q |=> cnt_o == $past(cnt_o) + 32'd1);
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_o));
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    tick && ld_pend_q |=> cnt_o == $past(ld_val));
endmodule

// File: rtl/rtc_event_ctrl.sv
module rtc_event_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] hit,
  input  logic [1:0] mask,
  input  logic       clr_wr,
  input  logic [1:0] clr_bits,
  input  logic       hib_active,
  input  logic       mwake_en,
  input  logic       pwake_en,
  input  logic       wake_pin_n,
  output logic [1:0] raw_o,
  output logic       irq_o,
  output logic       wake_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_s;
  logic [1:0]             clr_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], wake_pin_n};
  end
  assign pin_s = sync_q[SYNC_STAGES-1];

  assign clr_eff = clr_wr ? clr_bits : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_o <= '0;
    else        raw_o <= (raw_o & ~clr_eff) | hit;
  end

  assign irq_o  = |(raw_o & mask);
  assign wake_o = hib_active && ((mwake_en && (|hit)) || (pwake_en && !pin_s));

  a_r5_set0: assert property (@(posedge clk) disable iff (!rst_n) hit[0] |=> raw_o[0]);
  a_r5_set1: assert property (@(posedge clk) disable iff (!rst_n) hit[1] |=> raw_o[1]);
  a_r5_w1c0: assert property (@(posedge clk) disable iff (!rst_n)
    clr_eff[0] && !hit[0] |=> !raw_o[0]);
  a_r5_keep0: assert property (@(posedge clk) disable iff (!rst_n)
    raw_o[0] && !clr_eff[0] |=> raw_o[0]);
  a_r11_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
    !mwake_en && !pwake_en |-> !wake_o);
endmodule

// File: rtl/rtc_ret_mem.sv
module rtc_ret_mem #(
  parameter int WORDS = 64,
  localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] widx,
  input  logic [31:0]   wdata,
  input  logic [IW-1:0] ridx,
  output logic [31:0]   rdata
);
  logic [31:0] mem_q [WORDS];

  generate
    for (genvar g = 0; g < WORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  mem_q[g] <= '0;
        else if (wr_en && (widx == IW'(g)))          mem_q[g] <= wdata;
      end
      a_r12_retain: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (widx == IW'(g))) |=> $stable(mem_q[g]));
    end
  endgenerate

  assign rdata = mem_q[ridx];
endmodule

// File: rtl/rtc_hib_ctrl.sv
module rtc_hib_ctrl #(
  parameter int TICK_DIV    = 32768,
  parameter int RET_WORDS   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        wake_pin_n,
  output logic        hib_req_o,
  output logic        irq_o
);
  import rtc_hib_pkg::*;

  localparam int IW = (RET_WORDS > 1) ? $clog2(RET_WORDS) : 1;

  logic [31:0] match0_q, match1_q, load_q, ctrl_q;
  logic [1:0]  mask_q;
  logic        wr, ctrl_wr, load_wr, stat_wr, ret_wr, ret_sel;
  logic        tick, wake;
  logic [31:0] cnt;
  logic [1:0]  hit, raw;
  logic [IW-1:0] ret_idx;
  logic [31:0] ret_rdata;

  assign wr      = bus_sel && bus_wr;
  assign ctrl_wr = wr && (bus_addr == OFS_CTRL);
  assign load_wr = wr && (bus_addr == OFS_LOAD);
  assign stat_wr = wr && (bus_addr == OFS_STAT);
  assign ret_sel = ret_hit(bus_addr, RET_WORDS);
  assign ret_wr  = wr && ret_sel;
  assign ret_idx = IW'(ret_index(bus_addr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match0_q <= '0;
      match1_q <= '0;
      load_q   <= '0;
      mask_q   <= '0;
    end else if (wr) begin
      if (bus_addr == OFS_MATCH0) match0_q <= bus_wdata;
      if (bus_addr == OFS_MATCH1) match1_q <= bus_wdata;
      if (bus_addr == OFS_LOAD)   load_q   <= bus_wdata;
      if (bus_addr == OFS_MASK)   mask_q   <= bus_wdata[1:0];
    end
  end

  // A software write to the control word wins over a wake in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= bus_wdata & CTRL_WMASK;
    else if (wake)    ctrl_q[CB_HIB] <= 1'b0;
  end

  assign hib_req_o = ctrl_q[CB_HIB];

  rtc_tick_gen #(.TICK_DIV(TICK_DIV)) i_tick (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q[CB_CLKEN]), .tick_o(tick)
  );

  rtc_counter i_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctrl_q[CB_RUN]),
    .ld_wr(load_wr), .ld_val(load_q), .match0(match0_q), .match1(match1_q),
    .cnt_o(cnt), .hit_o(hit)
  );

  rtc_event_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_evt (
    .clk(clk), .rst_n(rst_n), .hit(hit), .mask(mask_q),
    .clr_wr(stat_wr), .clr_bits(bus_wdata[1:0]),
    .hib_active(ctrl_q[CB_HIB]), .mwake_en(ctrl_q[CB_MWAKE]),
    .pwake_en(ctrl_q[CB_PWAKE]), .wake_pin_n(wake_pin_n),
    .raw_o(raw), .irq_o(irq_o), .wake_o(wake)
  );

  rtc_ret_mem #(.WORDS(RET_WORDS)) i_ret (
    .clk(clk), .rst_n(rst_n), .wr_en(ret_wr), .widx(ret_idx),
    .wdata(bus_wdata), .ridx(ret_idx), .rdata(ret_rdata)
  );

  always_comb begin
    bus_rdata = '0;
    if (ret_sel) bus_rdata = ret_rdata;
    else begin
      case (bus_addr)
        OFS_COUNT:  bus_rdata = cnt;
        OFS_MATCH0: bus_rdata = match0_q;
        OFS_MATCH1: bus_rdata = match1_q;
        OFS_LOAD:   bus_rdata = load_q;
        OFS_CTRL:   bus_rdata = ctrl_q;
        OFS_MASK:   bus_rdata = {30'd0, mask_q};
        OFS_STAT:   bus_rdata = {30'd0, raw};
        OFS_MSTAT:  bus_rdata = {30'd0, raw & mask_q};
        default:    bus_rdata = '0;
      endcase
    end
  end

  a_r8_enter: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && bus_wdata[CB_HIB] |=> hib_req_o);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hib_req_o && !wake && !ctrl_wr |=> hib_req_o);
  a_r9_wake_drop: assert property (@(posedge clk) disable iff (!rst_n)
    wake && !ctrl_wr |=> !hib_req_o);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[5] == 1'b0 && ctrl_q[31:7] == '0);
endmodule

// File: tb/test_rtc_hib_ctrl.sv
module test_rtc_hib_ctrl;
  localparam int DIV = 8;
  localparam int NRET = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wake_pin_n = 1'b1;
  logic        hib_req_o, irq_o;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  rtc_hib_ctrl #(.TICK_DIV(DIV), .RET_WORDS(NRET), .SYNC_STAGES(2)) i_rtc_hib_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wake_pin_n(wake_pin_n), .hib_req_o(hib_req_o), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] pattern(input int i);
    return 32'hC3A5_0000 ^ (32'(i) * 32'h0101_0107);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic check_ret(input string tag);
    logic [31:0] d;
    for (int i = 0; i < NRET; i++) begin
      rd(12'h030 + 12'(4 * i), d);
      check(tag, d, pattern(i));
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(12'h010, d); check("R1 ctrl", d, 0);
    rd(12'h000, d); check("R1 count", d, 0);
    rd(12'h018, d); check("R1 status", d, 0);
    rd(12'h014, d); check("R1 mask", d, 0);
    rd(12'h12C, d); check("R1 ret last", d, 0);
    check("R1 hib_req", 32'(hib_req_o), 0);
    check("R1 irq", 32'(irq_o), 0);
  endtask

  task automatic t_ctrl_readback;
    logic [31:0] d;
    wr(12'h010, 32'h0000_0020);
    rd(12'h010, d); check("R2 bit5 reads 0", d, 0);
    wr(12'h010, 32'hFFFF_FF44);
    rd(12'h010, d); check("R2 clkmode+clken readback", d, 32'h44);
  endtask

  task automatic t_retention_fill;
    for (int i = 0; i < NRET; i++) wr(12'h030 + 12'(4 * i), pattern(i));
    check_ret("R12 readback");
  endtask

  task automatic t_load_count;
    logic [31:0] c0, c1;
    wr(12'h010, 32'h40);
    wr(12'h00C, 32'd50);
    cycles(2 * DIV);
    rd(12'h000, c0); check("R3 load applied", c0, 50);
    cycles(3 * DIV);
    rd(12'h000, c0); check("R4 hold when stopped", c0, 50);
    wr(12'h010, 32'h41);
    rd(12'h000, c0);
    cycles(8 * DIV);
    rd(12'h000, c1); check("R4 eight ticks", c1 - c0, 8);
    check("R7 no hibernation at 0x41", 32'(hib_req_o), 0);
    rd(12'h010, c1); check("R2 ctrl 0x41", c1, 32'h41);
  endtask

  task automatic t_match_irq;
    logic [31:0] c, d;
    wr(12'h018, 32'h3);
    rd(12'h018, d); check("R5 cleared", d, 0);
    rd(12'h000, c);
    wr(12'h004, c + 32'd3);
    cycles(5 * DIV);
    rd(12'h018, d); check("R5 match0 status", d, 32'h1);
    check("R6 masked off", 32'(irq_o), 0);
    wr(12'h014, 32'h2);
    check("R6 other mask bit", 32'(irq_o), 0);
    wr(12'h014, 32'h1);
    check("R6 irq on", 32'(irq_o), 1);
    rd(12'h01C, d); check("R6 masked status", d, 32'h1);
    wr(12'h018, 32'h0);
    rd(12'h018, d); check("R5 write 0 keeps", d, 32'h1);
    wr(12'h018, 32'h1);
    rd(12'h018, d); check("R5 W1C", d, 0);
    check("R6 irq off", 32'(irq_o), 0);
    wr(12'h014, 32'h0);
  endtask

  task automatic t_rtc_wake;
    logic [31:0] d;
    wr(12'h010, 32'h40);
    wr(12'h00C, 32'd100);
    cycles(2 * DIV);
    wr(12'h008, 32'd105);
    wr(12'h010, 32'h4F);
    check("R8 hib raised", 32'(hib_req_o), 1);
    wake_pin_n = 1'b0;
    cycles(10);
    wake_pin_n = 1'b1;
    cycles(3 * DIV - 10);
    check("R10 pin ignored when disabled", 32'(hib_req_o), 1);
    cycles(4 * DIV);
    check("R9 match wake dropped", 32'(hib_req_o), 0);
    rd(12'h010, d); check("R9 ctrl bit1 cleared", d, 32'h4D);
    rd(12'h018, d); check("R9 match1 status", d[1], 1);
    check_ret("R12 after rtc wake");
  endtask

  task automatic t_pin_wake;
    logic [31:0] d;
    wr(12'h010, 32'h56);
    cycles(4 * DIV);
    check("R8 hib holds", 32'(hib_req_o), 1);
    wake_pin_n = 1'b0;
    cycles(1);
    check("R10 sync delay", 32'(hib_req_o), 1);
    cycles(3);
    check("R10 pin wake", 32'(hib_req_o), 0);
    wake_pin_n = 1'b1;
    rd(12'h010, d); check("R10 ctrl bit1 cleared", d, 32'h54);
    check_ret("R12 after pin wake");
  endtask

  task automatic t_match_ignored;
    logic [31:0] d;
    wr(12'h010, 32'h40);
    wr(12'h00C, 32'd200);
    cycles(2 * DIV);
    wr(12'h018, 32'h3);
    wr(12'h004, 32'd202);
    wr(12'h010, 32'h57);
    cycles(5 * DIV);
    rd(12'h018, d); check("R11 status still set", d[0], 1);
    check("R11 match not a wake", 32'(hib_req_o), 1);
    wake_pin_n = 1'b0;
    cycles(4);
    check("R10 pin wake after ignored match", 32'(hib_req_o), 0);
    wake_pin_n = 1'b1;
  endtask

  task automatic t_both;
    logic [31:0] d;
    wr(12'h010, 32'h40);
    wr(12'h00C, 32'd300);
    cycles(2 * DIV);
    wr(12'h004, 32'd302);
    wr(12'h010, 32'h5F);
    check("R8 hib raised 0x5F", 32'(hib_req_o), 1);
    cycles(4 * DIV);
    check("R9 match wake with both", 32'(hib_req_o), 0);
    rd(12'h010, d); check("R9 ctrl 0x5D", d, 32'h5D);
    check_ret("R12 after combined wake");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_ctrl_readback();
    t_retention_fill();
    t_load_count();
    t_match_irq();
    t_rtc_wake();
    t_pin_wake();
    t_match_ignored();
    t_both();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule